// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Lookahead Adder

This block adds two 16-bit unsigned operands and a carry input and returns a 16-bit sum and a carry output. It has no clock, so a result settles within one path through the logic. The operand bits are split into four slices of four bits each. Every slice works out a generate and a propagate term for each bit, and then one generate and one propagate term for the whole slice. The carries inside a slice are written as flat sums of products. No carry passes from one bit cell to the next.

A second lookahead level takes the four slice terms and the block carry input. From these it forms the carry into each slice and the final carry output, each as one flat sum of products. The carry therefore never travels from one slice to the next. Bit propagate is the OR of the two operand bits. This gives correct carries because the sum bits use XOR, not propagate. The block is meant to sit inside a wider datapath as its integer adder.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + carry_i`, where the operands are read as unsigned.
- R2: `carry_o` equals bit 16 of the 17-bit unsigned total `a_i + b_i + carry_i`.
- R3: If `a_i` = 0xFFFF, `b_i` = 0x0000 and `carry_i` = 1, the carry crosses every slice. The result is `sum_o` = 0x0000 with `carry_o` = 1.
- R4: When the bits below a slice boundary at bit 4k (k = 1, 2, 3) are all ones in `a_i`, `b_i` is zero and `carry_i` = 1, that slice receives a carry. `sum_o` then has a single one at bit 4k and zeros below it. Example: 0x0FFF + 1 gives 0x1000.
- R5: If both operands are zero, `sum_o` equals `carry_i` in bit 0 with every other bit zero, and `carry_o` = 0.
- R6: Swapping `a_i` and `b_i` leaves `sum_o` and `carry_o` unchanged.
- R7: Bit 15 is treated as an ordinary value bit. 0x7FFF + 0x0001 with `carry_i` = 0 gives `sum_o` = 0x8000 and `carry_o` = 0. 0x7FFF + 0x0000 with `carry_i` = 1 gives the same result.
- R8: If both operands are 0xFFFF, `carry_o` = 1 for either value of `carry_i`, and `sum_o` = 0xFFFE + `carry_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| carry_o | output | 1 | Carry out of bit 15 |

## Verification
The block has no stored state, so a wrong internal term shows up at the ports as soon as the inputs apply it. A fault in a bit generate or propagate term, or in a slice carry, corrupts the sum bits at or above the failing position. A fault in a second-level carry flips the whole bottom bit of a slice, and it may also flip the carry output. The sweeps hold each slice in turn at every pair of nibble values, with both carry inputs. The bits around that slice are set so that the slice's carry into and out of its neighbours is exercised. Any wrong product term is therefore hit by some vector and is caught in the cycle that applies it.

// File: rtl/cla_pkg.sv
// Shared types for the lookahead adder.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cla_pkg;

    // Per-bit carry terms: generate and propagate.
    typedef struct packed {
        logic gen;
        logic prop;
    } bit_terms_t;

    // Per-slice carry terms handed to the second level.
    typedef struct packed {
        logic gen;
        logic prop;
    } slice_terms_t;

endpackage

// File: rtl/cla_bit_pg.sv
// Bit-level term cell: forms generate (AND) and propagate (OR)
// for one operand bit pair, plus the half-sum used for the sum bit.
// Assumes: purely combinational use.
module cla_bit_pg
    import cla_pkg::*;
(
    input  logic       x_i,
    input  logic       y_i,
    output bit_terms_t terms_o,
    output logic       half_o
);

    // Purpose: derive the per-bit generate/propagate and the XOR half-sum.
    always_comb begin
        terms_o.gen  = x_i & y_i;
        terms_o.prop = x_i | y_i;
        half_o       = x_i ^ y_i;
    end

endmodule

// File: rtl/cla_slice.sv
// Slice of SLICE_W bits. Every internal carry is a flat sum of
// products over the bit terms, so there is no ripple inside the slice.
// The slice also reports its own generate/propagate for the second level.
// Assumes: SLICE_W is small (a few bits), so the flat terms stay narrow.
module cla_slice
    import cla_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] x_i,
    input  logic [SLICE_W-1:0] y_i,
    input  logic               cin_i,
    output logic [SLICE_W-1:0] sum_o,
    output slice_terms_t       terms_o
);

    bit_terms_t         bt [SLICE_W];
    logic [SLICE_W-1:0] half;
    logic [SLICE_W-1:0] g;
    logic [SLICE_W-1:0] p;
    logic [SLICE_W:0]   c;

    // One term cell per bit of the slice.
    for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
        cla_bit_pg u_pg (
            .x_i    (x_i[i]),
            .y_i    (y_i[i]),
            .terms_o(bt[i]),
            .half_o (half[i])
        );
        assign g[i] = bt[i].gen;
        assign p[i] = bt[i].prop;
    end

    // Purpose: flat sum-of-products carry into each bit of the slice.
    always_comb begin
        c[0] = cin_i;
        for (int i = 0; i < SLICE_W; i++) begin
            logic acc;
            logic prod;
            prod = cin_i;
            for (int m = 0; m <= i; m++) prod = prod & p[m];
            acc = prod;
            for (int j = 0; j <= i; j++) begin
                logic t;
                t = g[j];
                for (int m = j + 1; m <= i; m++) t = t & p[m];
                acc = acc | t;
            end
            c[i+1] = acc;
        end
    end

    // Purpose: sum bits from the half-sums and the lookahead carries.
    always_comb begin
        for (int i = 0; i < SLICE_W; i++) sum_o[i] = half[i] ^ c[i];
    end

    // Purpose: slice generate (no carry-in term) and slice propagate.
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int j = 0; j < SLICE_W; j++) begin
            logic t;
            t = g[j];
            for (int m = j + 1; m < SLICE_W; m++) t = t & p[m];
            acc = acc | t;
        end
        terms_o.gen  = acc;
        terms_o.prop = &p;
    end

endmodule

// File: rtl/cla_lookahead.sv
// Second lookahead level. It turns the slice generate/propagate terms
// and the block carry-in into the carry for every slice and the final
// carry-out. Each carry is one flat sum of products; nothing chains.
// Assumes: N_SLICES is small (a handful), so term widths stay modest.
module cla_lookahead
    import cla_pkg::*;
#(
    parameter int N_SLICES = 4
) (
    input  slice_terms_t        terms_i [N_SLICES],
    input  logic                cin_i,
    output logic [N_SLICES-1:0] slice_cin_o,
    output logic                cout_o
);

    logic [N_SLICES-1:0] sg;
    logic [N_SLICES-1:0] sp;
    logic [N_SLICES:0]   cc;

    // Unpack the slice terms into vectors.
    for (genvar k = 0; k < N_SLICES; k++) begin : g_unpack
        assign sg[k] = terms_i[k].gen;
        assign sp[k] = terms_i[k].prop;
    end

    // Purpose: flat carry into each slice boundary k (cc[k] enters slice k).
    always_comb begin
        cc[0] = cin_i;
        for (int k = 1; k <= N_SLICES; k++) begin
            logic acc;
            logic prod;
            prod = cin_i;
            for (int m = 0; m < k; m++) prod = prod & sp[m];
            acc = prod;
            for (int j = 0; j < k; j++) begin
                logic t;
                t = sg[j];
                for (int m = j + 1; m < k; m++) t = t & sp[m];
                acc = acc | t;
            end
            cc[k] = acc;
        end
    end

    assign slice_cin_o = cc[N_SLICES-1:0];
    assign cout_o      = cc[N_SLICES];

endmodule

// File: rtl/cla16_adder.sv
// Top level: WIDTH-bit adder from WIDTH/SLICE_W lookahead slices, with a
// second lookahead level supplying every slice carry directly.
// Assumes: WIDTH is a multiple of SLICE_W; operands are unsigned.
module cla16_adder
    import cla_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int SLICE_W = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);

    localparam int N_SLICES = WIDTH / SLICE_W;

    slice_terms_t        st [N_SLICES];
    logic [N_SLICES-1:0] slice_cin;

    // One slice per SLICE_W-bit field of the operands.
    for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
        cla_slice #(.SLICE_W(SLICE_W)) u_slice (
            .x_i    (a_i[k*SLICE_W +: SLICE_W]),
            .y_i    (b_i[k*SLICE_W +: SLICE_W]),
            .cin_i  (slice_cin[k]),
            .sum_o  (sum_o[k*SLICE_W +: SLICE_W]),
            .terms_o(st[k])
        );
    end

    // Second-level lookahead across the slices.
    cla_lookahead #(.N_SLICES(N_SLICES)) u_look (
        .terms_i    (st),
        .cin_i      (carry_i),
        .slice_cin_o(slice_cin),
        .cout_o     (carry_o)
    );

endmodule

// File: rtl/cla16_adder_chk.sv
// Checker for the adder ports. The block holds no state, so the checks
// are immediate assertions evaluated whenever the ports settle.
// Assumes: bound to every instance of cla16_adder.
module cla16_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             carry_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_o
);

    // Purpose: port-level consistency checks against arithmetic.
    always_comb begin
        assert_sum_matches_R1: assert (sum_o == WIDTH'(a_i + b_i + WIDTH'(carry_i)))
            else $error("sum mismatch");
        assert_carry_matches_R2: assert (carry_o ==
            (({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i}) >> WIDTH))
            else $error("carry mismatch");
        if ((&a_i) && (b_i == '0) && carry_i)
            assert_full_ripple_R3: assert (carry_o && (sum_o == '0))
                else $error("full ripple wrong");
        if ((a_i == '0) && (b_i == '0))
            assert_zero_operands_R5: assert (!carry_o && (sum_o == {{(WIDTH-1){1'b0}}, carry_i}))
                else $error("zero operands wrong");
        if ((&a_i) && (&b_i))
            assert_both_ones_R8: assert (carry_o && (sum_o[WIDTH-1:1] == '1) && (sum_o[0] == carry_i))
                else $error("all-ones operands wrong");
    end

endmodule

bind cla16_adder cla16_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .carry_i(carry_i),
    .sum_o  (sum_o),
    .carry_o(carry_o)
);

// File: tb/cla16_adder_tb.sv
`timescale 1ns/1ps
// Bench: per-slice nibble sweeps, directed carry-chain cases and random
// vectors, each compared with a 17-bit arithmetic sum.
module cla16_adder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a, b;
    logic        cin;
    logic [15:0] sum;
    logic        cout;
    int          n_checks = 0;
    int          n_errors = 0;
    logic        done = 1'b0;

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    cla16_adder u_dut (
        .a_i    (a),
        .b_i    (b),
        .carry_i(cin),
        .sum_o  (sum),
        .carry_o(cout)
    );

    // Compare one output value with its expected value.
    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s a=%h b=%h cin=%0b actual=%h expected=%h", req, a, b, cin, act, exp);
        end
    endtask

    // Apply a vector at the falling edge; sample before the next rising edge.
    task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic ci);
        @(negedge clk);
        a = x; b = y; cin = ci;
        #1;
    endtask

    // Check sum (R1) and carry (R2) against the arithmetic total.
    task automatic check_arith(input logic [15:0] x, input logic [15:0] y, input logic ci);
        logic [16:0] tot;
        apply(x, y, ci);
        tot = {1'b0, x} + {1'b0, y} + {16'd0, ci};
        check("R1", {1'b0, sum}, {1'b0, tot[15:0]});
        check("R2", {16'd0, cout}, {16'd0, tot[16]});
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Initial state with idle inputs: zero result (R5).
        apply(16'h0000, 16'h0000, 1'b0);
        check("R5", {cout, sum}, 17'h0_0000);
        apply(16'h0000, 16'h0000, 1'b1);
        check("R5", {cout, sum}, 17'h0_0001);

        // Full-width ripple (R3).
        apply(16'hFFFF, 16'h0000, 1'b1);
        check("R3", {cout, sum}, 17'h1_0000);
        apply(16'h0000, 16'hFFFF, 1'b1);
        check("R3", {cout, sum}, 17'h1_0000);

        // Carry into each slice boundary (R4).
        for (int k = 1; k < 4; k++) begin
            logic [15:0] ones;
            ones = 16'((32'd1 << (4 * k)) - 1);
            apply(ones, 16'h0000, 1'b1);
            check("R4", {cout, sum}, {1'b0, 16'(32'd1 << (4 * k))});
            apply(ones - 16'd1, 16'h0001, 1'b1);
            check("R4", {cout, sum}, {1'b0, 16'(32'd1 << (4 * k))});
        end

        // Bit 15 is an ordinary value bit (R7).
        apply(16'h7FFF, 16'h0001, 1'b0);
        check("R7", {cout, sum}, 17'h0_8000);
        apply(16'h7FFF, 16'h0000, 1'b1);
        check("R7", {cout, sum}, 17'h0_8000);

        // Both operands all ones (R8).
        apply(16'hFFFF, 16'hFFFF, 1'b0);
        check("R8", {cout, sum}, 17'h1_FFFE);
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        check("R8", {cout, sum}, 17'h1_FFFF);

        // Per-slice exhaustive nibble sweep with neighbour fill patterns (R1, R2).
        for (int k = 0; k < 4; k++) begin
            for (int f = 0; f < 3; f++) begin
                logic [15:0] mask;
                logic [15:0] fill;
                mask = ~(16'hF << (4 * k));
                fill = (f == 0) ? 16'h0000 : (f == 1) ? 16'hFFFF : 16'h5A5A;
                for (int x = 0; x < 16; x++) begin
                    for (int y = 0; y < 16; y++) begin
                        for (int ci = 0; ci < 2; ci++) begin
                            check_arith((fill & mask) | (16'(x) << (4 * k)),
                                        16'(y) << (4 * k), 1'(ci));
                        end
                    end
                end
            end
        end

        // Random vectors, plus swapped-operand agreement (R6).
        for (int n = 0; n < 1500; n++) begin
            logic [15:0] x, y;
            logic        ci;
            logic [16:0] first;
            x = 16'($urandom);
            y = 16'($urandom);
            ci = 1'($urandom);
            check_arith(x, y, ci);
            first = {cout, sum};
            apply(y, x, ci);
            check("R6", {cout, sum}, first);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule